// File: doc/BRIEF.md
# Fifteen-Cent Coin Vending Controller

This block is a small synchronous controller for a single-slot coin acceptor. Each clock cycle it samples two coin pulses: one for a five-cent coin and one for a ten-cent coin. It keeps a running credit of 0, 5, 10 or 15 cents. Once the credit reaches 15 it raises a release signal for the item. It gives no change. Any credit above 15 is absorbed, and the machine stays at 15 until reset.

Two compile-time parameters select variants of the same credit machine. The first sets the timing of the release signal. With state-based output, the release follows the stored credit alone and rises one cycle after the final coin is sampled. With transition-based output, the release also rises during the cycle in which the final coin is presented. The second parameter sets how the state is held: a two-bit binary code or a four-bit one-hot vector. The encoding never changes what is visible at the ports. The coin and release pins are plain control pins. They are not streams, so there is no valid/ready handshake and no back-pressure.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no coins, the credit is 0 and the release output `vend_open_o` is low.
- R2: A five-cent pulse raises the credit by 5, and a ten-cent pulse raises it by 10. Three five-cent pulses, a five then a ten, or a ten then a five each reach 15.
- R3: In any cycle with no coin pulse, the credit is unchanged, so idle gaps between coins do not change when the release occurs.
- R4: A coin that would take the credit past 15 leaves it at 15. For example, two ten-cent pulses reach 15 with no other effect.
- R5: Once the credit is 15, the release stays high whatever coins arrive, until reset brings the credit back to 0.
- R6: With `MEALY_OUT` = 0, `vend_open_o` is high exactly while the stored credit is 15. It is low in the cycle that presents the final coin and high from the next cycle on.
- R7: With `MEALY_OUT` = 1, `vend_open_o` is high in the cycle that presents a coin which takes the credit to 15. That coin is a five at 10, or a ten at 5 or at 10. The output then stays high while the credit is 15.
- R8: If both coin pulses are high in the same cycle, the machine treats that cycle as a single ten-cent coin.
- R9: For a given `MEALY_OUT`, the binary (`ONE_HOT` = 0) and one-hot (`ONE_HOT` = 1) state encodings produce identical `vend_open_o` for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the credit to 0 |
| nickel_i | input | 1 | Five-cent coin pulse, sampled on the rising edge |
| dime_i | input | 1 | Ten-cent coin pulse, sampled on the rising edge |
| vend_open_o | output | 1 | Item release |

## Verification
The properties assume that the coin pulses are synchronous to `clk` and change only away from its rising edge. This matters most for the transition-based release, which depends combinationally on the pulses. The properties accept any pattern of pulses, including both pulses together, and they check the dime-wins rule (R8) rather than assuming it never happens. The stimulus drives every pulse just after a falling edge and holds it for one full cycle. It samples the release both just before the next rising edge and after it, so the same-cycle and next-cycle timings can be told apart.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int CRED_W = 2;
  typedef logic [CRED_W-1:0] credit_t;

  // Credit codes: value in cents is code * 5
  localparam credit_t CR_ZERO = 2'd0;
  localparam credit_t CR_FIVE = 2'd1;
  localparam credit_t CR_TEN  = 2'd2;
  localparam credit_t CR_FULL = 2'd3;

  localparam int OH_W = 4;
  typedef logic [OH_W-1:0] onehot_t;

  // Credit after one sampled cycle; a dime takes precedence over a nickel
  function automatic credit_t credit_step(credit_t cur, logic nk, logic dm);
    logic [CRED_W:0] sum;
    sum = {1'b0, cur} + (dm ? 3'd2 : (nk ? 3'd1 : 3'd0));
    if (sum > {1'b0, CR_FULL}) return CR_FULL;
    return sum[CRED_W-1:0];
  endfunction
endpackage

// File: rtl/vend_state_bin.sv
module vend_state_bin
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    nickel,
  input  logic    dime,
  output credit_t credit
);
  logic q_hi, q_lo;
  logic nk_eff;
  logic d_hi, d_lo;

  // Dime wins when both pulses appear
  assign nk_eff = nickel & ~dime;

  // Sum-of-products next-state equations for the two-bit code
  assign d_hi = q_hi | dime | (q_lo & nk_eff);
  assign d_lo = (~q_lo & nk_eff) | (q_lo & ~nk_eff) | (q_hi & nk_eff) | (q_hi & dime);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_hi <= 1'b0;
      q_lo <= 1'b0;
    end else begin
      q_hi <= d_hi;
      q_lo <= d_lo;
    end
  end

  assign credit = {q_hi, q_lo};
endmodule

// File: rtl/vend_state_onehot.sv
module vend_state_onehot
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    nickel,
  input  logic    dime,
  output credit_t credit
);
  onehot_t st_q, st_d;
  logic nk_eff, idle;

  assign nk_eff = nickel & ~dime;
  assign idle   = ~nickel & ~dime;

  // bit0 = 0c, bit1 = 5c, bit2 = 10c, bit3 = 15c
  always_comb begin
    st_d[0] = st_q[0] & idle;
    st_d[1] = (st_q[1] & idle) | (st_q[0] & nk_eff);
    st_d[2] = (st_q[2] & idle) | (st_q[1] & nk_eff) | (st_q[0] & dime);
    st_d[3] = st_q[3] | (st_q[2] & (nickel | dime)) | (st_q[1] & dime);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= onehot_t'(1);
    else        st_q <= st_d;
  end

  assign credit = {st_q[2] | st_q[3], st_q[1] | st_q[3]};
endmodule

// File: rtl/vend_open_gen.sv
module vend_open_gen
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input  credit_t credit,
  input  logic    nickel,
  input  logic    dime,
  output logic    open_o
);
  logic full, arc;

  assign full = (credit == CR_FULL);
  assign arc  = (credit != CR_FULL) && (credit_step(credit, nickel, dime) == CR_FULL);

  generate
    if (MEALY_OUT) begin : g_mealy
      assign open_o = full | arc;
    end else begin : g_moore
      logic unused_arc;
      assign unused_arc = arc;
      assign open_o = full;
    end
  endgenerate
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0,
  parameter bit ONE_HOT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nickel_i,
  input  logic dime_i,
  output logic vend_open_o
);
  credit_t cred_q;

  generate
    if (ONE_HOT) begin : g_oh
      vend_state_onehot u_state (
        .clk(clk), .rst_n(rst_n), .nickel(nickel_i), .dime(dime_i), .credit(cred_q)
      );
    end else begin : g_bin
      vend_state_bin u_state (
        .clk(clk), .rst_n(rst_n), .nickel(nickel_i), .dime(dime_i), .credit(cred_q)
      );
    end
  endgenerate

  vend_open_gen #(.MEALY_OUT(MEALY_OUT)) u_open (
    .credit(cred_q), .nickel(nickel_i), .dime(dime_i), .open_o(vend_open_o)
  );
endmodule

// File: rtl/vend_chk.sv
module vend_chk
  import vend_pkg::*;
#(
  parameter bit MEALY_OUT = 1'b0
) (
  input logic    clk,
  input logic    rst_n,
  input logic    nickel_i,
  input logic    dime_i,
  input logic    vend_open_o,
  input credit_t cred_q
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!nickel_i && !dime_i) |=> cred_q == $past(cred_q)); // R3

  AST_NICKEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (nickel_i && !dime_i && cred_q != CR_FULL) |=> cred_q == credit_t'($past(cred_q) + 2'd1)); // R2

  AST_DIME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dime_i && (cred_q == CR_ZERO || cred_q == CR_FIVE)) |=> cred_q == credit_t'($past(cred_q) + 2'd2)); // R8

  AST_DIME_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (dime_i && cred_q == CR_TEN) |=> cred_q == CR_FULL); // R4

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cred_q == CR_FULL) |=> cred_q == CR_FULL); // R5

  AST_OPEN_LEADS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    vend_open_o |=> cred_q == CR_FULL); // R7

  AST_MOORE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !MEALY_OUT |-> (vend_open_o == (cred_q == CR_FULL))); // R6

  AST_MEALY_ARC: assert property (@(posedge clk) disable iff (!rst_n)
    (MEALY_OUT && cred_q == CR_TEN && (nickel_i || dime_i)) |-> vend_open_o); // R7
endmodule

bind vend_ctrl vend_chk #(.MEALY_OUT(MEALY_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .nickel_i(nickel_i), .dime_i(dime_i),
  .vend_open_o(vend_open_o), .cred_q(cred_q)
);

// File: tb/sim_vend_ctrl.sv
`timescale 1ns/1ps
module sim_vend_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nk = 1'b0, dm = 1'b0;
  logic op0, op1, op2, op3;
  int n_chk = 0, n_fail = 0;
  int cr = 0; // model credit in cents

  always #5 clk = ~clk;

  vend_ctrl #(.MEALY_OUT(1'b0), .ONE_HOT(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .nickel_i(nk), .dime_i(dm), .vend_open_o(op0));
  vend_ctrl #(.MEALY_OUT(1'b0), .ONE_HOT(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .nickel_i(nk), .dime_i(dm), .vend_open_o(op1));
  vend_ctrl #(.MEALY_OUT(1'b1), .ONE_HOT(1'b0)) u2 (.clk(clk), .rst_n(rst_n), .nickel_i(nk), .dime_i(dm), .vend_open_o(op2));
  vend_ctrl #(.MEALY_OUT(1'b1), .ONE_HOT(1'b1)) u3 (.clk(clk), .rst_n(rst_n), .nickel_i(nk), .dime_i(dm), .vend_open_o(op3));

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Compare all four instances against model expectations
  task automatic check_all(string req, logic exp_moore, logic exp_mealy);
    check(req, "moore/bin", op0, exp_moore);
    check(req, "moore/onehot", op1, exp_moore);
    check(req, "mealy/bin", op2, exp_mealy);
    check(req, "mealy/onehot", op3, exp_mealy);
    check("R9", "moore encodings agree", op1, op0);
    check("R9", "mealy encodings agree", op3, op2);
  endtask

  // One cycle of stimulus: sample before the edge, then after it
  task automatic step(string req, logic n, logic d);
    int nxt;
    @(negedge clk);
    nk = n; dm = d;
    nxt = cr + (d ? 10 : (n ? 5 : 0));
    if (nxt > 15) nxt = 15;
    #4;
    check_all(req, cr == 15, nxt == 15);
    @(negedge clk);
    nk = 1'b0; dm = 1'b0;
    cr = nxt;
    #1;
    check_all(req, cr == 15, cr == 15);
  endtask

  task automatic do_reset();
    @(negedge clk);
    nk = 1'b0; dm = 1'b0;
    rst_n = 1'b0;
    #1;
    check_all("R1", 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cr = 0;
    #1;
    check_all("R1", 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    step("R1", 1'b0, 1'b0);
  endtask

  task automatic t_nnn();
    do_reset();
    step("R2", 1'b1, 1'b0);
    step("R2", 1'b1, 1'b0);
    step("R6", 1'b1, 1'b0); // final coin: mealy now, moore next cycle (R7 too)
    step("R7", 1'b0, 1'b0);
  endtask

  task automatic t_nd();
    do_reset();
    step("R2", 1'b1, 1'b0);
    step("R7", 1'b0, 1'b1);
    step("R6", 1'b0, 1'b0);
  endtask

  task automatic t_dn_gaps();
    do_reset();
    step("R2", 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step("R3", 1'b0, 1'b0);
    step("R7", 1'b1, 1'b0);
    step("R3", 1'b0, 1'b0);
  endtask

  task automatic t_dd();
    do_reset();
    step("R4", 1'b0, 1'b1);
    step("R4", 1'b0, 1'b1);
    step("R4", 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    do_reset();
    step("R5", 1'b0, 1'b1);
    step("R5", 1'b1, 1'b0);
    step("R5", 1'b1, 1'b0);
    step("R5", 1'b0, 1'b1);
    step("R5", 1'b0, 1'b0);
    do_reset(); // R5: only reset leaves full credit
    step("R5", 1'b0, 1'b0);
  endtask

  task automatic t_both();
    do_reset();
    step("R8", 1'b1, 1'b1); // counts as a dime: 10 cents, no release
    step("R8", 1'b1, 1'b0);
    do_reset();
    step("R8", 1'b1, 1'b0);
    step("R8", 1'b1, 1'b1); // 5 + dime reaches 15
  endtask

  initial begin
    #1;
    check_all("R1", 1'b0, 1'b0);
    t_reset();
    t_nnn();
    t_nd();
    t_dn_gaps();
    t_dd();
    t_hold();
    t_both();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule